// File: doc/BRIEF.md
# NAND On-Die ECC Feature Sequencer

This block drives a raw asynchronous NAND bus to switch the device's built-in error-correction engine on or off. A single start request, together with a requested enable value, launches a set-feature transfer: a command byte, one address byte naming the feature slot that gates on-die correction, and four parameter bytes. The sequencer then waits until the device reports ready on its ready/busy line.

When the caller also asks for verification, the block goes on to a get-feature transfer. This is a command byte, the same address byte, a wait for ready, and four read strobes. It compares the correction-enable bit of the first returned byte against the requested value. The caller sees a one-cycle done pulse at the end of the sequence. A confirmed level is held until the next accepted start. A mismatch pulse or a timeout pulse accompanies done when something went wrong.

Every strobe width, the minimum wait before ready is trusted, and the ready timeout are parameter cycle counts. Page reads, programs, erases and bad-block handling are not part of this block.

Top module: `nfeat_ecc_seq`

## Requirements
- R1: While reset is held and after it is released with no start, chip enable, write strobe and read strobe are high (inactive), CLE, ALE, the data output enable, busy, done, mismatch, timeout and confirmed are all low.
- R2: A start in idle produces six write cycles in this order: command EFh with CLE high, address 90h with ALE high, then four data cycles with both CLE and ALE low. CLE and ALE are never high together.
- R3: The first data byte is 08h (bit 3 set) when enable_req was 1 at start and 00h when it was 0. The other three data bytes are always 00h.
- R4: Each write cycle holds the write strobe low for T_WL cycles and then high for T_WH cycles. CLE, ALE and the data byte stay constant across the rising strobe edge. Each read cycle holds the read strobe low for T_RL cycles and high for T_RH cycles. The two strobes are never low at the same time.
- R5: After the last set-feature data byte, and after the get-feature address, the block issues no strobe for at least T_WB cycles and until the synchronised ready/busy input reads high.
- R6: When verify was 1 at start, the ready wait is followed by command EEh (CLE high), address 90h (ALE high), a second ready wait, and four read cycles. When verify was 0, no get-feature cycles are issued.
- R7: confirmed goes high when bit 3 of the first read byte equals the requested enable value. It stays high until the next accepted start. If the bit differs, mismatch pulses together with done and confirmed stays low.
- R8: If ready does not return within T_TO cycles of a wait, the sequence ends. timeout pulses with done, and confirmed stays low.
- R9: done is a single-cycle pulse at the end of every accepted sequence. busy is high from the cycle after an accepted start through the done cycle. A start while busy is ignored and issues no further command.
- R10: With the device ready at once, done rises 6·(T_WL+T_WH)+T_WB cycles after the start edge when verify is 0. When verify is 1, it rises 8·(T_WL+T_WH)+2·T_WB+4·(T_RL+T_RH) cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sequence request, taken only when idle |
| enable_req | input | 1 | 1 = turn on-die correction on, 0 = off |
| verify | input | 1 | 1 = read the feature back after setting it |
| nand_rb_n | input | 1 | Device ready/busy, low = busy (asynchronous) |
| nand_dq_in | input | 8 | Data bus from the device |
| nand_dq_out | output | 8 | Data bus to the device |
| nand_dq_oe | output | 1 | Drive enable for nand_dq_out |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| confirmed | output | 1 | Read-back matched the request |
| mismatch | output | 1 | Read-back differed, pulses with done |
| timeout | output | 1 | Ready never returned, pulses with done |

## Verification
The bench drives start across one clock edge and counts the cycles until done is seen. With an always-ready device model, the count must match the R10 formula exactly: 27 cycles without verification and 54 with it, for the bench's strobe widths. Outputs are read at the falling edge, half a cycle after the registered state changes. The captured bus bytes are taken at the first falling edge that shows the write strobe high again, which is where the device latches. The flags mismatch, timeout and confirmed are sampled in the same falling-edge slot as the done pulse, because the design updates them together. A stuck-busy device model is used to show that the timeout ends the sequence after T_TO waiting cycles.

// File: rtl/nfeat_pkg.sv
package nfeat_pkg;
  localparam logic [7:0] CMD_SET_FEAT = 8'hEF;
  localparam logic [7:0] CMD_GET_FEAT = 8'hEE;

  localparam int STEP_W = 4;
  localparam logic [STEP_W-1:0] SP_SCMD  = 4'd0;
  localparam logic [STEP_W-1:0] SP_SADDR = 4'd1;
  localparam logic [STEP_W-1:0] SP_SD0   = 4'd2;
  localparam logic [STEP_W-1:0] SP_SD3   = 4'd5;
  localparam logic [STEP_W-1:0] SP_GCMD  = 4'd6;
  localparam logic [STEP_W-1:0] SP_GADDR = 4'd7;
  localparam logic [STEP_W-1:0] SP_RD0   = 4'd8;
  localparam logic [STEP_W-1:0] SP_RD3   = 4'd11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WLOW, ST_WHIGH, ST_WAITB, ST_RLOW, ST_RHIGH, ST_FIN
  } seq_state_t;
endpackage

// File: rtl/nfeat_sync.sv
module nfeat_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nfeat_stepdec.sv
module nfeat_stepdec
  import nfeat_pkg::*;
#(
  parameter logic [7:0] FEAT_ADDR = 8'h90,
  parameter int         ECC_BIT   = 3
) (
  input  logic [STEP_W-1:0] step,
  input  logic              en,
  output logic              cle,
  output logic              ale,
  output logic [7:0]        bus_byte
);
  localparam logic [7:0] EN_BYTE = 8'(1) << ECC_BIT;

  always_comb begin
    cle      = 1'b0;
    ale      = 1'b0;
    bus_byte = 8'h00;
    case (step)
      SP_SCMD:  begin cle = 1'b1; bus_byte = CMD_SET_FEAT; end
      SP_SADDR: begin ale = 1'b1; bus_byte = FEAT_ADDR; end
      SP_SD0:   bus_byte = en ? EN_BYTE : 8'h00;
      SP_GCMD:  begin cle = 1'b1; bus_byte = CMD_GET_FEAT; end
      SP_GADDR: begin ale = 1'b1; bus_byte = FEAT_ADDR; end
      default:  bus_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/nfeat_ecc_seq.sv
module nfeat_ecc_seq
  import nfeat_pkg::*;
#(
  parameter int         T_WL        = 2,
  parameter int         T_WH        = 2,
  parameter int         T_RL        = 2,
  parameter int         T_RH        = 2,
  parameter int         T_WB        = 4,
  parameter int         T_TO        = 4096,
  parameter int         SYNC_STAGES = 2,
  parameter int         ECC_BIT     = 3,
  parameter logic [7:0] FEAT_ADDR   = 8'h90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       enable_req,
  input  logic       verify,
  input  logic       nand_rb_n,
  input  logic [7:0] nand_dq_in,
  output logic [7:0] nand_dq_out,
  output logic       nand_dq_oe,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic       nand_ce_n,
  output logic       busy,
  output logic       done,
  output logic       confirmed,
  output logic       mismatch,
  output logic       timeout
);
  localparam int TM_A = (T_WL > T_WH) ? T_WL : T_WH;
  localparam int TM_B = (T_RL > T_RH) ? T_RL : T_RH;
  localparam int TM_C = (T_WB > T_TO) ? T_WB : T_TO;
  localparam int TM_D = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int TMAX = (TM_C > TM_D) ? TM_C : TM_D;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [7:0] ECC_MASK = 8'(1) << ECC_BIT;

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              en_q, en_d, ver_q, ver_d, to_q, to_d, conf_q, conf_d;
  logic              rdy;
  logic              dec_cle, dec_ale;
  logic [7:0]        dec_byte;
  logic              wphase, bit_match;

  nfeat_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb_n), .q(rdy)
  );

  nfeat_stepdec #(.FEAT_ADDR(FEAT_ADDR), .ECC_BIT(ECC_BIT)) u_dec (
    .step(step_q), .en(en_q), .cle(dec_cle), .ale(dec_ale), .bus_byte(dec_byte)
  );

  assign bit_match = ((nand_dq_in & ECC_MASK) == (en_q ? ECC_MASK : 8'h00));

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    cnt_d   = cnt_q;
    en_d    = en_q;
    ver_d   = ver_q;
    to_d    = to_q;
    conf_d  = conf_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_WLOW;
        step_d  = SP_SCMD;
        cnt_d   = '0;
        en_d    = enable_req;
        ver_d   = verify;
        to_d    = 1'b0;
        conf_d  = 1'b0;
      end
      ST_WLOW: if (cnt_q == CW'(T_WL - 1)) begin
        state_d = ST_WHIGH;
        cnt_d   = '0;
      end else cnt_d = cnt_q + 1'b1;
      ST_WHIGH: if (cnt_q == CW'(T_WH - 1)) begin
        cnt_d = '0;
        if (step_q == SP_SD3 || step_q == SP_GADDR) state_d = ST_WAITB;
        else begin
          step_d  = step_q + 1'b1;
          state_d = ST_WLOW;
        end
      end else cnt_d = cnt_q + 1'b1;
      ST_WAITB: if (cnt_q >= CW'(T_WB - 1) && rdy) begin
        cnt_d = '0;
        if (step_q == SP_SD3) begin
          if (ver_q) begin
            step_d  = SP_GCMD;
            state_d = ST_WLOW;
          end else state_d = ST_FIN;
        end else begin
          step_d  = SP_RD0;
          state_d = ST_RLOW;
        end
      end else if (cnt_q == CW'(T_TO - 1)) begin
        to_d    = 1'b1;
        state_d = ST_FIN;
      end else cnt_d = cnt_q + 1'b1;
      ST_RLOW: if (cnt_q == CW'(T_RL - 1)) begin
        cnt_d   = '0;
        state_d = ST_RHIGH;
        if (step_q == SP_RD0) conf_d = bit_match;
      end else cnt_d = cnt_q + 1'b1;
      ST_RHIGH: if (cnt_q == CW'(T_RH - 1)) begin
        cnt_d = '0;
        if (step_q == SP_RD3) state_d = ST_FIN;
        else begin
          step_d  = step_q + 1'b1;
          state_d = ST_RLOW;
        end
      end else cnt_d = cnt_q + 1'b1;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= SP_SCMD;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      ver_q   <= 1'b0;
      to_q    <= 1'b0;
      conf_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      cnt_q   <= cnt_d;
      en_q    <= en_d;
      ver_q   <= ver_d;
      to_q    <= to_d;
      conf_q  <= conf_d;
    end
  end

  assign wphase      = (state_q == ST_WLOW) || (state_q == ST_WHIGH);
  assign nand_cle    = wphase & dec_cle;
  assign nand_ale    = wphase & dec_ale;
  assign nand_dq_oe  = wphase;
  assign nand_dq_out = wphase ? dec_byte : 8'h00;
  assign nand_we_n   = (state_q != ST_WLOW);
  assign nand_re_n   = (state_q != ST_RLOW);
  assign nand_ce_n   = (state_q == ST_IDLE) || (state_q == ST_FIN);
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_FIN);
  assign timeout     = done & to_q;
  assign mismatch    = done & ver_q & ~to_q & ~conf_q;
  assign confirmed   = conf_q;
endmodule

// File: rtl/nfeat_ecc_seq_chk.sv
module nfeat_ecc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] nand_dq_out,
  input logic       nand_dq_oe,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_ce_n,
  input logic       busy,
  input logic       done,
  input logic       confirmed,
  input logic       mismatch,
  input logic       timeout
);
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nand_cle && nand_ale)); // R2
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) !nand_we_n |-> (!nand_ce_n && nand_dq_oe)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!nand_we_n && !nand_re_n)); // R4
  AST_SETUP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_dq_out))); // R4
  AST_MISMATCH_NOT_CONF: assert property (@(posedge clk) disable iff (!rst_n) mismatch |-> (done && !confirmed)); // R7
  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) timeout |-> (done && !mismatch && !confirmed)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy)); // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R9
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> (busy && !nand_we_n && nand_cle)); // R2
endmodule

bind nfeat_ecc_seq nfeat_ecc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .nand_dq_out(nand_dq_out),
  .nand_dq_oe(nand_dq_oe), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n),
  .busy(busy), .done(done), .confirmed(confirmed), .mismatch(mismatch),
  .timeout(timeout)
);

// File: tb/nfeat_ecc_seq_test.sv
module nfeat_ecc_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int P_WL = 2, P_WH = 2, P_RL = 2, P_RH = 2, P_WB = 3, P_TO = 40;
  localparam int BUSY_LEN = 8;
  localparam int WD_LIMIT = 100000;

  logic       clk, rst_n, start, enable_req, verify, nand_rb_n;
  logic [7:0] nand_dq_in, nand_dq_out;
  logic       nand_dq_oe, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n;
  logic       busy, done, confirmed, mismatch, timeout;

  int checks = 0, fails = 0, cyc = 0;

  // device model state
  logic [9:0] cap [0:15];
  int         ncap = 0, nset = 0, nget = 0, data_idx = 0, read_idx = 0, busy_left = 0;
  logic       prev_we = 1'b1, prev_re = 1'b1, in_set = 1'b0, in_get = 1'b0;
  logic       use_busy = 1'b0, stuck = 1'b0, corrupt = 1'b0;
  logic [7:0] feat = 8'h00;

  nfeat_ecc_seq #(
    .T_WL(P_WL), .T_WH(P_WH), .T_RL(P_RL), .T_RH(P_RH), .T_WB(P_WB), .T_TO(P_TO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .enable_req(enable_req), .verify(verify),
    .nand_rb_n(nand_rb_n), .nand_dq_in(nand_dq_in), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n),
    .busy(busy), .done(done), .confirmed(confirmed), .mismatch(mismatch),
    .timeout(timeout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign nand_rb_n  = !(stuck || busy_left > 0);
  assign nand_dq_in = (read_idx == 0) ? (feat ^ (corrupt ? 8'h08 : 8'h00)) : 8'h00;

  always @(negedge clk) begin
    if (busy_left > 0) busy_left <= busy_left - 1;
    if (!prev_we && nand_we_n) begin
      if (ncap < 16) cap[ncap] <= {nand_cle, nand_ale, nand_dq_out};
      ncap <= ncap + 1;
      if (nand_cle) begin
        in_set   <= (nand_dq_out == 8'hEF);
        in_get   <= (nand_dq_out == 8'hEE);
        data_idx <= 0;
        if (nand_dq_out == 8'hEF) nset <= nset + 1;
        if (nand_dq_out == 8'hEE) nget <= nget + 1;
      end else if (nand_ale) begin
        if (in_get) begin
          read_idx <= 0;
          if (use_busy) busy_left <= BUSY_LEN;
        end
      end else if (in_set) begin
        if (data_idx == 0) feat <= nand_dq_out;
        if (data_idx == 3 && use_busy) busy_left <= BUSY_LEN;
        data_idx <= data_idx + 1;
      end
    end
    if (!prev_re && nand_re_n) read_idx <= read_idx + 1;
    prev_we <= nand_we_n;
    prev_re <= nand_re_n;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL R9 watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic en, input logic ver,
                     output int lat, output logic mm, output logic to, output logic cf);
    ncap = 0; nset = 0; nget = 0;
    @(negedge clk);
    start = 1'b1; enable_req = en; verify = ver;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin
      lat = lat + 1;
      @(negedge clk);
    end
    mm = mismatch; to = timeout; cf = confirmed;
    @(negedge clk);
    chk("R9 done single pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 ce_n", {31'd0, nand_ce_n}, 32'd1);
    chk("R1 we_n/re_n", {30'd0, nand_we_n, nand_re_n}, 32'd3);
    chk("R1 cle/ale/oe", {29'd0, nand_cle, nand_ale, nand_dq_oe}, 32'd0);
    chk("R1 busy/done/flags", {27'd0, busy, done, confirmed, mismatch, timeout}, 32'd0);
  endtask

  task automatic t_enable_noverify;
    int lat; logic mm, to, cf;
    use_busy = 1'b0;
    run(1'b1, 1'b0, lat, mm, to, cf);
    chk("R10 latency no verify", lat, 6*(P_WL+P_WH)+P_WB);
    chk("R2 write cycle count", ncap, 6);
    chk("R2 cmd EF with CLE", {22'd0, cap[0]}, 32'h2EF);
    chk("R2 addr 90 with ALE", {22'd0, cap[1]}, 32'h190);
    chk("R3 first data 08", {22'd0, cap[2]}, 32'h008);
    chk("R3 reserved bytes 00", {12'd0, cap[3][9:0] | cap[4][9:0] | cap[5][9:0]}, 32'd0);
    chk("R6 no get-feature", nget, 0);
    chk("R7 no confirm without verify", {29'd0, cf, mm, to}, 32'd0);
  endtask

  task automatic t_enable_verify_timing;
    int lat; logic mm, to, cf;
    use_busy = 1'b0;
    run(1'b1, 1'b1, lat, mm, to, cf);
    chk("R10 latency with verify", lat, 8*(P_WL+P_WH)+2*P_WB+4*(P_RL+P_RH));
    chk("R6 cmd EE with CLE", {22'd0, cap[6]}, 32'h2EE);
    chk("R6 addr 90 with ALE", {22'd0, cap[7]}, 32'h190);
    chk("R6 four reads", read_idx, 4);
    chk("R7 confirmed enable", {29'd0, cf, mm, to}, 32'd4);
  endtask

  task automatic t_disable_busy;
    int lat; logic mm, to, cf;
    use_busy = 1'b1;
    run(1'b0, 1'b1, lat, mm, to, cf);
    chk("R3 first data 00 on disable", {22'd0, cap[2]}, 32'h000);
    chk("R5 busy wait lengthens run", {31'd0, lat > 8*(P_WL+P_WH)+2*P_WB+4*(P_RL+P_RH)}, 32'd1);
    chk("R7 confirmed disable", {29'd0, cf, mm, to}, 32'd4);
    chk("R7 confirmed held after done", {31'd0, confirmed}, 32'd1);
  endtask

  task automatic t_mismatch;
    int lat; logic mm, to, cf;
    use_busy = 1'b1; corrupt = 1'b1;
    run(1'b0, 1'b1, lat, mm, to, cf);
    corrupt = 1'b0;
    chk("R7 mismatch pulse", {29'd0, cf, mm, to}, 32'd2);
  endtask

  task automatic t_timeout;
    int lat; logic mm, to, cf;
    use_busy = 1'b0; stuck = 1'b1;
    run(1'b1, 1'b1, lat, mm, to, cf);
    stuck = 1'b0;
    chk("R8 timeout pulse", {29'd0, cf, mm, to}, 32'd1);
    chk("R8 timeout latency", lat, 6*(P_WL+P_WH)+P_TO);
    chk("R8 no get after timeout", nget, 0);
  endtask

  task automatic t_start_while_busy;
    int lat; logic mm, to, cf;
    use_busy = 1'b1;
    fork
      run(1'b1, 1'b1, lat, mm, to, cf);
      begin
        repeat (12) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    repeat (10) @(negedge clk);
    chk("R9 start while busy ignored", nset, 1);
    chk("R9 idle after done", {31'd0, busy}, 32'd0);
    chk("R7 confirmed after ignored start", {31'd0, confirmed}, 32'd1);
  endtask

  initial begin
    start = 1'b0; enable_req = 1'b0; verify = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_enable_noverify;
    t_enable_verify_timing;
    t_disable_busy;
    t_mismatch;
    t_timeout;
    t_start_while_busy;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule